// File: doc/BRIEF.md
# Double-Buffered SPI Master

This block is an SPI master that a small host processor drives through six byte-wide registers. The host puts a byte into a transmit holding register. The engine copies it into an 8-bit shift register, generates the serial clock and drives slave select low, and shifts the byte out most significant bit first. At the same time it collects the incoming serial bits. Each finished byte goes into a receive holding register.

The transmit side has its own holding stage, and so does the receive side. The host can therefore queue the next byte and read the last one while the current byte is on the wire. A continuous stream then runs with no idle serial clock between bytes. The serial clock is the system clock divided by a power of two between 4 and 128. Holding-register flags and a sticky overrun flag drive a single level interrupt through per-flag enables.

Top module: `dbuf_spi_master`

## Requirements
- R1: After reset, `spi_sclk` is 0, `spi_ss_n` is 1, `spi_mosi` is 0 and `irq` is 0. The status register (address 5) reads 0x01 and every other register reads 0.
- R2: With divide select `s` (address 4, bits 2:0), each serial clock half period lasts `2<<min(s,5)` system clocks, so the clock divides by 4 to 128. The clock idles low. `spi_mosi` changes on each rising edge, MSB first, and `spi_miso` is sampled on each falling edge.
- R3: A write to transmit data (address 2) is accepted only while the block is enabled and the transmit holding register is empty. A write while it is full leaves the held byte unchanged, and no extra byte is sent. Transmit data reads as 0.
- R4: If a byte is held when the eighth falling edge completes a transfer, the next byte starts in that same cycle. Its first rising edge follows one half period later, and slave select stays low. A two-byte burst keeps `spi_ss_n` low for exactly `32*half` cycles.
- R5: `spi_ss_n` falls when a byte is taken from the empty shift stage. It rises only when a byte completes and nothing is held. Status bit 3 reads 1 while a transfer is in progress. The clock is low whenever slave select is high.
- R6: A completed byte is copied into receive data (address 3) and sets status bit 1. A read of address 3 returns the byte and clears bit 1.
- R7: Overrun is status bit 2. It sets when a byte completes while bit 1 is set and no read of address 3 happens in that same cycle, and the previously received byte is kept. Writing 1 to status bit 2 clears overrun, but a new overrun in the same cycle wins. The flag is sticky.
- R8: Control (address 0) bit 0 enables the block. While it reads 0, the shift engine and both holding flags are cleared, the clock is low, `spi_ss_n` is 1 and `spi_mosi` is 0. Transmit writes are ignored, and overrun keeps its value.
- R9: `irq` is the OR of three terms: status bit 0 (transmit empty) AND enable bit 0, status bit 1 AND enable bit 1, and status bit 2 AND enable bit 2. The enables are bits 2:0 of address 1.
- R10: Control, interrupt enable and divide select read back the values written, in bits 0, 2:0 and 2:0 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a read of address 3 pops the receive stage) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_ss_n | output | 1 | Slave select, active low |
| irq | output | 1 | Level interrupt |

## Verification
Overrun is the hardest state to reach from the ports. It needs two bytes to finish back to back while the first received byte sits unread, and the second byte must be queued in the narrow window after the first leaves the holding register. The bench waits one idle cycle after the first write before it writes the second byte. It then tries a third write at once, which must be dropped. After that it reads nothing until the pair has finished. A behavioural model with a byte queue tracks the pins and the readback on every clock. Each pin and register value is compared against that model.

// File: rtl/dbuf_spi_master.sv
module dbuf_spi_master #(
  parameter int DW      = 8,
  parameter int MAX_SEL = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          spi_sclk,
  output logic          spi_mosi,
  input  logic          spi_miso,
  output logic          spi_ss_n,
  output logic          irq
);
  localparam int HW = $clog2(2 << MAX_SEL) + 1;
  localparam int BW = $clog2(DW);
  localparam logic [2:0] A_CTRL = 3'd0, A_IE = 3'd1, A_TX = 3'd2,
                         A_RX = 3'd3, A_DIV = 3'd4, A_STAT = 3'd5;

  logic          en, tx_full, rx_full, ovr, active, sclk_q, mosi_q, ss_q;
  logic [2:0]    ie, sel;
  logic [DW-1:0] txbuf, rxbuf, sh;
  logic [HW-1:0] hcnt;
  logic [BW-1:0] bitcnt;

  wire [2:0]    sel_eff = (sel > 3'(MAX_SEL)) ? 3'(MAX_SEL) : sel;
  wire [HW-1:0] half    = HW'(2) << sel_eff;

  wire wr_tx   = bus_wr && bus_addr == A_TX && en && !tx_full;
  wire rd_rx   = bus_rd && bus_addr == A_RX;
  wire clr_ovr = bus_wr && bus_addr == A_STAT && bus_wdata[2];
  wire edge_now = active && hcnt == half - HW'(1);
  wire rise    = edge_now && !sclk_q;
  wire fall    = edge_now && sclk_q;
  wire done    = fall && bitcnt == BW'(DW - 1);
  wire start   = en && !active && tx_full;
  wire reload  = done && tx_full;
  wire consume = start || reload;
  wire store   = done && (!rx_full || rd_rx);
  wire overrun = done && rx_full && !rd_rx;
  wire [DW-1:0] rx_word = {sh[DW-2:0], spi_miso};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en  <= 1'b0;
      ie  <= '0;
      sel <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_CTRL) en  <= bus_wdata[0];
      if (bus_addr == A_IE)   ie  <= bus_wdata[2:0];
      if (bus_addr == A_DIV)  sel <= bus_wdata[2:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_full <= 1'b0;
      rx_full <= 1'b0;
      txbuf   <= '0;
      rxbuf   <= '0;
    end else if (!en) begin
      tx_full <= 1'b0;
      rx_full <= 1'b0;
    end else begin
      if (wr_tx) txbuf <= bus_wdata;
      tx_full <= (tx_full && !consume) || wr_tx;
      if (store) rxbuf <= rx_word;
      rx_full <= (rx_full && !rd_rx) || store;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       ovr <= 1'b0;
    else if (overrun) ovr <= 1'b1;
    else if (clr_ovr) ovr <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      active <= 1'b0;
      sclk_q <= 1'b0;
      mosi_q <= 1'b0;
      ss_q   <= 1'b1;
      hcnt   <= '0;
      bitcnt <= '0;
      sh     <= '0;
    end else if (!en) begin
      active <= 1'b0;
      sclk_q <= 1'b0;
      mosi_q <= 1'b0;
      ss_q   <= 1'b1;
      hcnt   <= '0;
      bitcnt <= '0;
    end else if (consume) begin
      active <= 1'b1;
      ss_q   <= 1'b0;
      sclk_q <= 1'b0;
      sh     <= txbuf;
      hcnt   <= '0;
      bitcnt <= '0;
    end else if (active) begin
      if (edge_now) begin
        hcnt   <= '0;
        sclk_q <= ~sclk_q;
        if (rise) mosi_q <= sh[DW-1];
        else begin
          sh     <= rx_word;
          bitcnt <= bitcnt + BW'(1);
          if (done) begin
            active <= 1'b0;
            ss_q   <= 1'b1;
          end
        end
      end else begin
        hcnt <= hcnt + HW'(1);
      end
    end

  always_comb
    case (bus_addr)
      A_CTRL:  bus_rdata = {{(DW-1){1'b0}}, en};
      A_IE:    bus_rdata = {{(DW-3){1'b0}}, ie};
      A_RX:    bus_rdata = rxbuf;
      A_DIV:   bus_rdata = {{(DW-3){1'b0}}, sel};
      A_STAT:  bus_rdata = {{(DW-4){1'b0}}, active, ovr, rx_full, ~tx_full};
      default: bus_rdata = '0;
    endcase

  assign spi_sclk = sclk_q;
  assign spi_mosi = mosi_q;
  assign spi_ss_n = ss_q;
  assign irq      = |({ovr, rx_full, ~tx_full} & ie);
endmodule

module dbuf_spi_master_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    bus_addr,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic          clr_bit,
  input logic          spi_sclk,
  input logic          spi_ss_n,
  input logic          en,
  input logic          tx_full,
  input logic          rx_full,
  input logic          ovr,
  input logic          done,
  input logic [DW-1:0] txbuf,
  input logic [DW-1:0] rxbuf
);
  assert_idle_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    spi_ss_n |-> !spi_sclk);

  assert_tx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    en && tx_full && bus_wr && bus_addr == 3'd2 |=> txbuf == $past(txbuf));

  assert_select_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_ss_n) |-> $past(tx_full));

  assert_rx_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    en && bus_rd && bus_addr == 3'd3 && !done |=> !rx_full);

  assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovr && !(bus_wr && bus_addr == 3'd5 && clr_bit) |=> ovr);

  assert_rx_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    en && rx_full && !(bus_rd && bus_addr == 3'd3) |=> $stable(rxbuf));

  assert_disable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> spi_ss_n && !spi_sclk && !tx_full && !rx_full);
endmodule

bind dbuf_spi_master dbuf_spi_master_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .clr_bit(bus_wdata[2]), .spi_sclk(spi_sclk),
  .spi_ss_n(spi_ss_n), .en(en), .tx_full(tx_full), .rx_full(rx_full),
  .ovr(ovr), .done(done), .txbuf(txbuf), .rxbuf(rxbuf)
);

// File: tb/tb_dbuf_spi_master.sv
module tb_dbuf_spi_master;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [2:0] b_addr = 3'd0;
  logic       b_wr = 1'b0, b_rd = 1'b0;
  logic [7:0] b_wdata = 8'd0;
  logic [7:0] b_rdata;
  logic       spi_sclk, spi_mosi, spi_ss_n, irq;
  wire        spi_miso = ~spi_mosi;

  always #10 clk = ~clk;

  dbuf_spi_master dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(b_addr), .bus_wr(b_wr), .bus_rd(b_rd),
    .bus_wdata(b_wdata), .bus_rdata(b_rdata), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_ss_n(spi_ss_n), .irq(irq)
  );

  integer checks = 0, failures = 0;
  bit     finished = 0;

  task automatic chk(input bit ok, input string tag, input integer act, input integer exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference
  bit         m_en = 0, m_rxf = 0, m_ovr = 0, m_act = 0, m_sclk = 0, m_mosi = 0, m_ss = 1;
  bit [2:0]   m_ie = 0, m_sel = 0;
  bit [7:0]   m_rxd = 0, m_cur = 0, m_got = 0;
  bit [7:0]   m_txq[$];
  integer     m_t = 0, half = 2, k = 0;
  bit         o_en, acc;

  function automatic bit [7:0] m_read(input bit [2:0] a);
    case (a)
      3'd0: return {7'd0, m_en};
      3'd1: return {5'd0, m_ie};
      3'd3: return m_rxd;
      3'd4: return {5'd0, m_sel};
      3'd5: return {4'd0, m_act, m_ovr, m_rxf, m_txq.size() == 0};
      default: return 8'd0;
    endcase
  endfunction

  function automatic bit m_irq();
    return ((m_txq.size() == 0) && m_ie[0]) || (m_rxf && m_ie[1]) || (m_ovr && m_ie[2]);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_rxf = 0; m_ovr = 0; m_act = 0; m_sclk = 0; m_mosi = 0; m_ss = 1;
      m_ie = 0; m_sel = 0; m_rxd = 0; m_txq.delete();
    end else begin
      o_en = m_en;
      half = 2 << ((m_sel > 5) ? 5 : m_sel);
      acc  = o_en && b_wr && b_addr == 3'd2 && m_txq.size() == 0;
      if (b_wr && b_addr == 3'd5 && b_wdata[2]) m_ovr = 0;
      if (!o_en) begin
        m_txq.delete(); m_rxf = 0; m_act = 0; m_sclk = 0; m_mosi = 0; m_ss = 1;
      end else begin
        if (b_rd && b_addr == 3'd3) m_rxf = 0;
        if (!m_act) begin
          if (m_txq.size() != 0) begin
            m_cur = m_txq.pop_front(); m_act = 1; m_t = 0; m_ss = 0; m_sclk = 0; m_got = 0;
          end
        end else begin
          m_t++;
          if (m_t % half == 0) begin
            k = m_t / half;
            if (k % 2 == 1) begin
              m_sclk = 1;
              m_mosi = m_cur[7 - (k - 1) / 2];
            end else begin
              m_sclk = 0;
              m_got = {m_got[6:0], ~m_mosi};
              if (k == 16) begin
                if (m_rxf) m_ovr = 1;
                else begin m_rxf = 1; m_rxd = m_got; end
                if (m_txq.size() != 0) begin
                  m_cur = m_txq.pop_front(); m_t = 0; m_got = 0;
                end else begin
                  m_act = 0; m_ss = 1;
                end
              end
            end
          end
        end
      end
      if (b_wr) case (b_addr)
        3'd0: m_en  = b_wdata[0];
        3'd1: m_ie  = b_wdata[2:0];
        3'd4: m_sel = b_wdata[2:0];
        default: ;
      endcase
      if (acc) m_txq.push_back(b_wdata);
    end
  end

  always @(negedge clk) if (rst_n && !finished)
    chk(spi_sclk == m_sclk && spi_mosi == m_mosi && spi_ss_n == m_ss && irq == m_irq(),
        "R2 R4 R5 R9 pins", {spi_sclk, spi_mosi, spi_ss_n, irq},
        {m_sclk, m_mosi, m_ss, m_irq()});

  integer ss_low = 0;
  always @(negedge clk) if (!spi_ss_n) ss_low++;

  task automatic wr(input bit [2:0] a, input bit [7:0] d);
    @(negedge clk); b_addr = a; b_wr = 1; b_wdata = d;
    @(negedge clk); b_wr = 0;
  endtask

  task automatic rd(input bit [2:0] a, output bit [7:0] v);
    @(negedge clk); b_addr = a; b_rd = 1;
    #1;
    v = b_rdata;
    chk(b_rdata == m_read(a), "R10 readback vs model", b_rdata, m_read(a));
    @(negedge clk); b_rd = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (spi_ss_n && !m_act && m_txq.size() == 0) return;
    end
  endtask

  initial begin
    #3000000;
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    chk(spi_sclk == 0 && spi_ss_n == 1 && spi_mosi == 0 && irq == 0, "R1 reset pins",
        {spi_sclk, spi_ss_n, spi_mosi, irq}, 4'b0100);
    rst_n = 1;
    rd(3'd5, v); chk(v == 8'h01, "R1 reset status", v, 8'h01);
    rd(3'd0, v); chk(v == 8'h00, "R1 reset control", v, 0);
    rd(3'd4, v); chk(v == 8'h00, "R1 reset divide", v, 0);

    wr(3'd1, 8'h00); wr(3'd4, 8'h00); wr(3'd0, 8'h01);
    rd(3'd0, v); chk(v == 8'h01, "R10 control readback", v, 1);
    wr(3'd2, 8'hA5);
    rd(3'd2, v); chk(v == 8'h00, "R3 transmit reads zero", v, 0);
    wait_idle();
    rd(3'd5, v); chk(v == 8'h03, "R6 rx full after byte", v, 8'h03);
    rd(3'd3, v); chk(v == 8'h5A, "R6 received byte MSB first", v, 8'h5A);
    rd(3'd5, v); chk(v == 8'h01, "R6 read clears full", v, 8'h01);

    wr(3'd4, 8'h01);
    rd(3'd4, v); chk(v == 8'h01, "R10 divide readback", v, 1);
    ss_low = 0;
    wr(3'd2, 8'h3C);
    @(negedge clk);
    wr(3'd2, 8'hC3);
    wr(3'd2, 8'h11);
    wait_idle();
    chk(ss_low == 128, "R4 burst select low time", ss_low, 128);
    rd(3'd5, v); chk(v == 8'h07, "R7 overrun set, R3 third byte dropped", v, 8'h07);
    rd(3'd3, v); chk(v == 8'hC3, "R7 old byte kept", v, 8'hC3);
    wr(3'd5, 8'h04);
    rd(3'd5, v); chk(v == 8'h01, "R7 overrun cleared", v, 8'h01);

    wr(3'd1, 8'h01); chk(irq == 1, "R9 tx empty irq", irq, 1);
    wr(3'd1, 8'h06); chk(irq == 0, "R9 masked idle", irq, 0);
    rd(3'd1, v); chk(v == 8'h06, "R10 enable readback", v, 8'h06);
    wr(3'd1, 8'h00);

    wr(3'd4, 8'h07);
    wr(3'd2, 8'hF0);
    n = 0;
    for (int i = 0; i < 500 && !spi_sclk; i++) @(negedge clk);
    for (int i = 0; i < 500 && spi_sclk; i++) begin n++; @(negedge clk); end
    chk(n == 64, "R2 clamped half period", n, 64);
    wait_idle();
    wr(3'd1, 8'h02); chk(irq == 1, "R9 rx full irq", irq, 1);
    rd(3'd3, v); chk(v == 8'h0F, "R6 slow byte", v, 8'h0F);
    chk(irq == 0, "R9 irq drops after read", irq, 0);

    wr(3'd4, 8'h02);
    wr(3'd2, 8'h81);
    repeat (20) @(negedge clk);
    wr(3'd0, 8'h00);
    @(negedge clk);
    chk(spi_ss_n == 1 && spi_sclk == 0 && spi_mosi == 0, "R8 disable idles pins",
        {spi_ss_n, spi_sclk, spi_mosi}, 3'b100);
    rd(3'd5, v); chk(v == 8'h01, "R8 disable clears flags", v, 8'h01);
    wr(3'd2, 8'h55);
    wr(3'd0, 8'h01);
    repeat (5) @(negedge clk);
    rd(3'd5, v); chk(v == 8'h01, "R8 write while disabled ignored", v, 8'h01);
    chk(spi_ss_n == 1, "R5 no transfer started", spi_ss_n, 1);

    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule